// File: doc/BRIEF.md
# DMA Page-Table Address Translator

This block turns one logical DMA transfer into a stream of physical chunk requests. A command carries a logical start address, a byte count and a direction. The block cuts the transfer at page boundaries. For each page it fetches one translation entry from a table in memory, and it issues a chunk request that carries the physical address, the chunk length and the direction. The block moves no data itself. It produces only the address stream and the chunk lengths, and it ends each command with a one-cycle done pulse or a one-cycle abort pulse.

The table base and the table limit (in bytes) are static inputs. Each table entry is 8 bytes wide. The low 32-bit word of an entry holds the frame address, and the block reads only that word, through a simple request/valid memory port. It keeps at most one table read in flight. When a page index falls outside the table, the walk stops, and every chunk issued up to that point remains valid.

Top module: `dma_xlate_walker`

## Requirements
- R1: After reset the block is idle: `busy`, `done`, `abort`, `mem_rd_req` and `chunk_valid` are all low.
- R2: A command with a byte count of zero produces a `done` pulse in the cycle after it is accepted. It raises no `mem_rd_req` and no `chunk_valid`.
- R3: For each page, the table read address equals the table base plus 8 times the page index. The page index is the logical address shifted right by 12 (the page size is 4096 bytes).
- R4: A page index that is greater than or equal to floor(limit / 8) raises `abort` for one cycle and issues no table read for that page. The chunks issued for earlier pages of the same command still go out.
- R5: The physical chunk address equals the 32-bit frame word returned for the entry, plus the low 12 bits of the current logical address.
- R6: Each chunk length equals 4096 minus the page offset, clipped to the bytes still remaining. The logical address advances by that length, so the chunk lengths of a command that is not aborted add up to its byte count.
- R7: `done` pulses for exactly one cycle, in the cycle after the chunk that uses up the byte count. `done` and `abort` are never high together, and neither is high while `busy` is high.
- R8: At most one table read is outstanding. After `mem_rd_req`, no new read is issued until `mem_rd_data_valid` has returned, and the block waits as long as the return takes.
- R9: A command presented while `busy` is high is ignored. The chunk stream of the running command is unchanged.
- R10: `chunk_dir` equals the direction bit of the command that produced the chunk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_base | input | 32 | Byte address of translation table entry 0 |
| tbl_limit | input | 32 | Table size in bytes; valid entries are floor(limit/8) |
| cmd_valid | input | 1 | Start a command (taken only while idle) |
| cmd_addr | input | 32 | Logical start address |
| cmd_len | input | 16 | Byte count |
| cmd_dir | input | 1 | Transfer direction, passed through to chunks |
| mem_rd_req | output | 1 | One-cycle table read request |
| mem_rd_addr | output | 32 | Byte address of the entry being read |
| mem_rd_data_valid | input | 1 | Entry frame word is present |
| mem_rd_data | input | 32 | Low word of the entry (frame address) |
| chunk_valid | output | 1 | One-cycle chunk request |
| chunk_addr | output | 32 | Physical address of the chunk |
| chunk_len | output | 16 | Chunk length in bytes |
| chunk_dir | output | 1 | Direction of the chunk |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle completion pulse |
| abort | output | 1 | One-cycle pulse on a table-limit violation |

## Verification
The bench sweeps start offsets at a page start, one byte in, mid-page and the last byte of a page. It combines these with byte counts of one byte, exactly a page, a page plus one and several pages. This separates the clipping of the first chunk from the full-page middle chunks and the short tail. Start pages near the end of the table, plus a limit that is not a multiple of 8, show whether the abort fires at the right index and only after the legal chunks have gone out. Table-read latencies that vary from one to three cycles, commands injected in mid-walk and zero-length commands check the single-outstanding rule, the ignoring of commands while busy and the immediate completion path.

// File: rtl/xlt_pkg.sv
package xlt_pkg;
  // Walker state encoding
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_WAIT  = 2'd2,
    ST_ISSUE = 2'd3
  } walk_st_e;
endpackage

// File: rtl/xlt_chunk_calc.sv
module xlt_chunk_calc #(
  parameter int AW        = 32,
  parameter int LW        = 16,
  parameter int PAGE_BITS = 12,
  parameter int ENT_LOG2  = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue,
  input  logic [AW-1:0] cur_addr,
  input  logic [LW-1:0] remain,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] limit,
  input  logic [AW-1:0] frame,
  output logic [AW-1:0] entry_addr,
  output logic          in_range,
  output logic [LW-1:0] chunk,
  output logic [AW-1:0] phys_addr,
  output logic [AW-1:0] next_addr,
  output logic          last
);
  localparam int IW   = AW - PAGE_BITS;
  localparam int PAGE = 1 << PAGE_BITS;
  localparam int ENTB = 1 << ENT_LOG2;

  function automatic logic [IW-1:0] page_idx(input logic [AW-1:0] a);
    return a[AW-1:PAGE_BITS];
  endfunction

  function automatic logic [PAGE_BITS-1:0] page_off(input logic [AW-1:0] a);
    return a[PAGE_BITS-1:0];
  endfunction

  function automatic logic [AW-1:0] ent_addr(input logic [AW-1:0] b, input logic [IW-1:0] i);
    logic [AW-1:0] scaled;
    scaled = AW'({i, {ENT_LOG2{1'b0}}});
    return b + scaled;
  endfunction

  // entry i exists when 8*(i+1) <= limit, i.e. i < floor(limit/8)
  function automatic logic idx_ok(input logic [IW-1:0] i, input logic [AW-1:0] lim);
    logic [AW:0] top;
    top = (AW+1)'({i, {ENT_LOG2{1'b0}}}) + (AW+1)'(ENTB);
    return top <= {1'b0, lim};
  endfunction

  function automatic logic [LW-1:0] clip_len(input logic [PAGE_BITS-1:0] o, input logic [LW-1:0] r);
    logic [PAGE_BITS:0] room;
    room = (PAGE_BITS+1)'(PAGE) - {1'b0, o};
    return (r < LW'(room)) ? r : LW'(room);
  endfunction

  logic [IW-1:0]        idx;
  logic [PAGE_BITS-1:0] off;

  always_comb begin
    idx        = page_idx(cur_addr);
    off        = page_off(cur_addr);
    entry_addr = ent_addr(base, idx);
    in_range   = idx_ok(idx, limit);
    chunk      = clip_len(off, remain);
    phys_addr  = frame + AW'(off);
    next_addr  = cur_addr + AW'(chunk);
    last       = (remain == chunk);
  end

  // R6: an issued chunk never runs past the end of its page
  page_cross_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue |-> ((AW+1)'(off) + (AW+1)'(chunk)) <= (AW+1)'(PAGE));
endmodule

// File: rtl/xlt_walk_fsm.sv
module xlt_walk_fsm
  import xlt_pkg::*;
#(
  parameter int AW        = 32,
  parameter int LW        = 16,
  parameter int PAGE_BITS = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [AW-1:0] cmd_addr,
  input  logic [LW-1:0] cmd_len,
  input  logic          cmd_dir,
  input  logic          rd_valid,
  input  logic [AW-1:0] rd_frame,
  input  logic          in_range,
  input  logic [LW-1:0] chunk,
  input  logic [AW-1:0] next_addr,
  input  logic          last,
  output logic [AW-1:0] cur_addr,
  output logic [LW-1:0] remain,
  output logic [AW-1:0] frame,
  output logic          dir,
  output logic          rd_req,
  output logic          issue,
  output logic          busy,
  output logic          done,
  output logic          abort
);
  localparam int PAGE = 1 << PAGE_BITS;

  walk_st_e st;

  assign rd_req = (st == ST_FETCH) && in_range;
  assign issue  = (st == ST_ISSUE);
  assign busy   = (st != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      cur_addr <= '0;
      remain   <= '0;
      frame    <= '0;
      dir      <= 1'b0;
      done     <= 1'b0;
      abort    <= 1'b0;
    end else begin
      done  <= 1'b0;
      abort <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (cmd_valid) begin
            if (cmd_len == '0) begin
              done <= 1'b1;
            end else begin
              cur_addr <= cmd_addr;
              remain   <= cmd_len;
              dir      <= cmd_dir;
              st       <= ST_FETCH;
            end
          end
        end
        ST_FETCH: begin
          if (in_range) begin
            st <= ST_WAIT;
          end else begin
            abort <= 1'b1;
            st    <= ST_IDLE;
          end
        end
        ST_WAIT: begin
          if (rd_valid) begin
            frame <= rd_frame;
            st    <= ST_ISSUE;
          end
        end
        ST_ISSUE: begin
          cur_addr <= next_addr;
          remain   <= remain - chunk;
          if (last) begin
            done <= 1'b1;
            st   <= ST_IDLE;
          end else begin
            st <= ST_FETCH;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R8
  single_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> !rd_req);

  // R7
  end_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && abort));

  // R7
  idle_on_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done || abort) |-> !busy);

  // R6
  chunk_len_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue |-> (chunk != '0) && (chunk <= LW'(PAGE)));

  // R2
  zero_len_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cmd_valid && cmd_len == '0) |=> (done && !busy));
endmodule

// File: rtl/dma_xlate_walker.sv
module dma_xlate_walker #(
  parameter int AW        = 32,
  parameter int LW        = 16,
  parameter int PAGE_BITS = 12,
  parameter int ENT_LOG2  = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] tbl_base,
  input  logic [AW-1:0] tbl_limit,
  input  logic          cmd_valid,
  input  logic [AW-1:0] cmd_addr,
  input  logic [LW-1:0] cmd_len,
  input  logic          cmd_dir,
  output logic          mem_rd_req,
  output logic [AW-1:0] mem_rd_addr,
  input  logic          mem_rd_data_valid,
  input  logic [AW-1:0] mem_rd_data,
  output logic          chunk_valid,
  output logic [AW-1:0] chunk_addr,
  output logic [LW-1:0] chunk_len,
  output logic          chunk_dir,
  output logic          busy,
  output logic          done,
  output logic          abort
);
  logic [AW-1:0] cur_addr, frame, entry_addr, phys_addr, next_addr;
  logic [LW-1:0] remain, chunk;
  logic          in_range, last, issue, dir, rd_req;

  xlt_walk_fsm #(.AW(AW), .LW(LW), .PAGE_BITS(PAGE_BITS)) fsm_i (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_addr(cmd_addr), .cmd_len(cmd_len), .cmd_dir(cmd_dir),
    .rd_valid(mem_rd_data_valid), .rd_frame(mem_rd_data),
    .in_range(in_range), .chunk(chunk), .next_addr(next_addr), .last(last),
    .cur_addr(cur_addr), .remain(remain), .frame(frame), .dir(dir),
    .rd_req(rd_req), .issue(issue), .busy(busy), .done(done), .abort(abort)
  );

  xlt_chunk_calc #(.AW(AW), .LW(LW), .PAGE_BITS(PAGE_BITS), .ENT_LOG2(ENT_LOG2)) calc_i (
    .clk(clk), .rst_n(rst_n), .issue(issue),
    .cur_addr(cur_addr), .remain(remain), .base(tbl_base), .limit(tbl_limit),
    .frame(frame), .entry_addr(entry_addr), .in_range(in_range), .chunk(chunk),
    .phys_addr(phys_addr), .next_addr(next_addr), .last(last)
  );

  assign mem_rd_req  = rd_req;
  assign mem_rd_addr = entry_addr;
  assign chunk_valid = issue;
  assign chunk_addr  = phys_addr;
  assign chunk_len   = chunk;
  assign chunk_dir   = dir;

  // R2
  no_read_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_rd_req && !chunk_valid));
endmodule

// File: tb/dma_xlate_walker_tb_top.sv
module dma_xlate_walker_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] BASE = 32'h0002_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] tbl_base = BASE;
  logic [31:0] tbl_limit = 32'd128;
  logic        cmd_valid = 1'b0;
  logic [31:0] cmd_addr = '0;
  logic [15:0] cmd_len = '0;
  logic        cmd_dir = 1'b0;
  logic        mem_rd_req;
  logic [31:0] mem_rd_addr;
  logic        mem_rd_data_valid = 1'b0;
  logic [31:0] mem_rd_data = '0;
  logic        chunk_valid;
  logic [31:0] chunk_addr;
  logic [15:0] chunk_len;
  logic        chunk_dir;
  logic        busy, done, abort;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;
  int cmd_no = 0;

  logic [31:0] exp_rd   [0:63];
  logic [31:0] exp_addr [0:63];
  int          exp_len  [0:63];
  int          exp_n;
  bit          exp_abort;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_xlate_walker dut_i (
    .clk(clk), .rst_n(rst_n), .tbl_base(tbl_base), .tbl_limit(tbl_limit),
    .cmd_valid(cmd_valid), .cmd_addr(cmd_addr), .cmd_len(cmd_len), .cmd_dir(cmd_dir),
    .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
    .mem_rd_data_valid(mem_rd_data_valid), .mem_rd_data(mem_rd_data),
    .chunk_valid(chunk_valid), .chunk_addr(chunk_addr), .chunk_len(chunk_len),
    .chunk_dir(chunk_dir), .busy(busy), .done(done), .abort(abort)
  );

  function automatic logic [31:0] frame_of(input logic [31:0] ea);
    return (ea * 32'd9) + 32'h0004_0321;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Expected stream from the requirements' arithmetic
  task automatic build(input logic [31:0] a0, input int len);
    longint a, idx, off, c, r;
    a = a0; r = len; exp_n = 0; exp_abort = 0;
    while (r > 0) begin
      idx = a / 4096;
      if (idx >= longint'(tbl_limit) / 8) begin exp_abort = 1; break; end
      exp_rd[exp_n] = BASE + 32'(idx * 8);
      off = a % 4096;
      c = 4096 - off;
      if (c > r) c = r;
      exp_addr[exp_n] = frame_of(exp_rd[exp_n]) + 32'(off);
      exp_len[exp_n] = int'(c);
      exp_n++;
      a += c; r -= c;
    end
  endtask

  task automatic run(input logic [31:0] a, input int len, input bit d, input bit inject);
    int rd_seen = 0, ck_seen = 0, wait_cnt = 0, cyc = 0;
    logic [31:0] last_rd = '0;
    bit ended = 0;
    build(a, len);
    cmd_no++;
    cmd_valid = 1'b1; cmd_addr = a; cmd_len = 16'(len); cmd_dir = d;
    @(negedge clk);
    cmd_valid = 1'b0;
    while (!ended && cyc < 400) begin
      if (mem_rd_data_valid) mem_rd_data_valid = 1'b0;
      if (wait_cnt > 0) begin
        wait_cnt--;
        if (wait_cnt == 0) begin
          mem_rd_data_valid = 1'b1;
          mem_rd_data = frame_of(last_rd);
        end
      end
      if (mem_rd_req) begin
        // R8: no new read while one is pending
        check(wait_cnt == 0 && !mem_rd_data_valid, "R8", wait_cnt, 0);
        // R3 / R4: table address in order, no read past the limit
        if (rd_seen < exp_n) check(mem_rd_addr == exp_rd[rd_seen], "R3", mem_rd_addr, exp_rd[rd_seen]);
        else check(0, "R4", rd_seen, exp_n);
        last_rd = mem_rd_addr;
        wait_cnt = 1 + ((cmd_no + rd_seen) % 3);
        rd_seen++;
      end
      if (chunk_valid) begin
        if (ck_seen < exp_n) begin
          check(chunk_addr == exp_addr[ck_seen], "R5", chunk_addr, exp_addr[ck_seen]);
          check(int'(chunk_len) == exp_len[ck_seen], "R6", chunk_len, exp_len[ck_seen]);
          check(chunk_dir == d, "R10", chunk_dir, d);
        end else check(0, "R6", ck_seen, exp_n);
        ck_seen++;
      end
      if (inject && cyc == 3) begin
        cmd_valid = 1'b1; cmd_addr = 32'h0000_7000; cmd_len = 16'd1; cmd_dir = ~d;
      end else begin
        cmd_valid = 1'b0;
      end
      if (done || abort) begin
        ended = 1;
        check(abort == exp_abort, exp_abort ? "R4" : "R7", abort, exp_abort);
        check(!(done && abort), "R7", done, 0);
        check(ck_seen == exp_n, inject ? "R9" : "R6", ck_seen, exp_n);
        check(rd_seen == exp_n, "R3", rd_seen, exp_n);
        if (len == 0) check(cyc == 0, "R2", cyc, 0);
      end
      @(negedge clk);
      cyc++;
    end
    cmd_valid = 1'b0;
    mem_rd_data_valid = 1'b0;
    if (!ended) check(0, "R7", cyc, 0);
    // R7: pulse lasts one cycle and block is idle
    check(!done && !abort && !busy, "R7", {done, abort, busy}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: idle after reset
    check(!busy && !done && !abort && !mem_rd_req && !chunk_valid, "R1",
          {busy, done, abort, mem_rd_req, chunk_valid}, 0);
    // R2: zero-length commands
    run(32'h0000_1234, 0, 1'b0, 1'b0);
    run(32'h00FF_F000, 0, 1'b1, 1'b0);
    begin
      logic [31:0] offs [0:3];
      logic [31:0] pgs  [0:2];
      int lens [0:5];
      offs = '{32'h0, 32'h1, 32'h7FF, 32'hFFF};
      pgs  = '{32'd0, 32'd3, 32'd14};
      lens = '{1, 2, 4095, 4096, 4097, 9000};
      for (int p = 0; p < 3; p++)
        for (int o = 0; o < 4; o++)
          for (int l = 0; l < 6; l++)
            run((pgs[p] << 12) + offs[o], lens[l], 1'((p + o + l) % 2), l >= 4);
    end
    // R4: start beyond the table, and a limit not a multiple of 8
    run(32'h0001_0000, 100, 1'b0, 1'b0);
    run(32'h1234_5678, 5, 1'b1, 1'b0);
    tbl_limit = 32'd135;
    run(32'h0000_F800, 5000, 1'b1, 1'b0);
    tbl_limit = 32'd127;
    run(32'h0000_E010, 8000, 1'b0, 1'b0);
    run(32'h0000_0000, 65535, 1'b1, 1'b1);
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule